// File: doc/BRIEF.md
# Two-Wire Slave Command Front End

This block is the bit-level slave end of a two-wire serial bus. The bus lines are sampled in the system clock domain. It finds start and stop conditions and collects bytes MSB first. It answers only to an address byte that carries the fixed device-type nibble and the four strapped address bits. The slave acknowledges by pulling the data line low during the ninth clock. It never drives the line high: the data output is an output-enable that pulls low or releases.

Once addressed, the slave passes the instruction byte and an optional data byte to a command executor. Each byte arrives with a one-cycle strobe. By the end of the instruction acknowledge, the executor picks what follows:
- a write byte;
- a read byte, which the slave shifts out from the executor's data;
- a raw stream, in which every SCL clock reports the SDA level as an up or down step.

While the executor reports a nonvolatile write as busy, the slave refuses its address. A master can therefore poll for completion.

Top module: `twi_cmd_front`

## Requirements
- R1: During and after reset, `sda_oe_o` is 0 and no strobe (`inst_vld_o`, `data_vld_o`, `step_vld_o`, `stop_o`) is raised.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Bits clocked before the first start are not acknowledged and raise no strobe.
- R3: The address byte matches only when its bits [7:4] are 4'b0101 and its bits [3:0] equal `dev_addr_i`. A mismatching byte is not acknowledged, and the rest of the frame raises no strobe.
- R4: A matched address, the instruction byte and the first data byte are each acknowledged with SDA held low through the ninth SCL high phase. `sda_oe_o` rises only while SCL is low.
- R5: If `nv_busy_i` is 1 when the address byte completes, the address is not acknowledged, even when it matches.
- R6: The instruction byte appears on `byte_o` with a one-cycle `inst_vld_o` pulse. The data byte appears on `byte_o` with a one-cycle `data_vld_o` pulse.
- R7: If `rd_mode_i` is 1 at the end of the instruction acknowledge, the slave sends `rd_data_i` MSB first over the next eight clocks. It releases SDA for the ninth clock.
- R8: If `stream_mode_i` is 1 at the end of the instruction acknowledge, every later SCL rising edge gives one `step_vld_o` pulse, with `step_up_o` equal to the SDA level. This continues until a stop or start.
- R9: A start in the middle of a byte aborts the transfer, and the next eight bits are taken as a fresh address byte.
- R10: `stop_o` pulses once on a stop that ends an addressed frame. A stop ending an unaddressed frame gives no pulse.
- R11: After the data byte, further bytes in the same frame are not acknowledged and raise no strobe.
- R12: At most one of `inst_vld_o`, `data_vld_o`, `step_vld_o` is high in any cycle, and each is high for only one cycle at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw bus clock level |
| sda_i | input | 1 | Raw bus data level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| dev_addr_i | input | 4 | Strapped address bits |
| nv_busy_i | input | 1 | Executor nonvolatile write pending |
| rd_mode_i | input | 1 | Next byte is read from the slave |
| stream_mode_i | input | 1 | Next clocks are raw up/down steps |
| rd_data_i | input | 8 | Byte to send in read mode |
| inst_vld_o | output | 1 | Instruction byte strobe |
| data_vld_o | output | 1 | Data byte strobe |
| byte_o | output | 8 | Last received byte |
| step_vld_o | output | 1 | Stream clock strobe |
| step_up_o | output | 1 | SDA level for the step |
| stop_o | output | 1 | Stop ending an addressed frame |

## Verification
Random write frames mix matching addresses with wrong strap bits and wrong type nibbles. The bench computes the acknowledge from the match rule, which separates a correct compare from one that ignores a nibble. Directed frames cover the cases where a single path would hide a fault:
- a busy poll followed by a successful one;
- a read of a random byte, which catches bit-order errors;
- a stream of random levels whose up and down counts must both match;
- a restart mid-byte, a trailing extra byte, and bits clocked before any start.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_INST,
    PH_DATA,
    PH_READ,
    PH_STREAM,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int         STAGES  = 2,
  parameter int         W       = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  // SDA moving while SCL stays high marks a condition, not data
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
  import twi_pkg::*;
#(
  parameter int              ADDR_W   = 4,
  parameter int              BYTE_W   = 8,
  parameter logic [BYTE_W-ADDR_W-1:0] DEV_TYPE = 4'b0101
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic              nv_busy_i,
  input  logic              rd_mode_i,
  input  logic              stream_mode_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              inst_vld_o,
  output logic              data_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              step_vld_o,
  output logic              step_up_o,
  output logic              stop_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ack_slot_q;
  logic              sel_q;
  logic [BYTE_W-1:0] shift_q;
  logic [BYTE_W-1:0] tx_q;
  logic              oe_q;
  logic              addr_hit;

  assign addr_hit = (shift_q[BYTE_W-1:ADDR_W] == DEV_TYPE) &&
                    (shift_q[ADDR_W-1:0] == dev_addr_i) && !nv_busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      cnt_q      <= '0;
      ack_slot_q <= 1'b0;
      sel_q      <= 1'b0;
      shift_q    <= '0;
      tx_q       <= '0;
      oe_q       <= 1'b0;
      inst_vld_o <= 1'b0;
      data_vld_o <= 1'b0;
      byte_o     <= '0;
      step_vld_o <= 1'b0;
      step_up_o  <= 1'b0;
      stop_o     <= 1'b0;
    end else begin
      inst_vld_o <= 1'b0;
      data_vld_o <= 1'b0;
      step_vld_o <= 1'b0;
      stop_o     <= 1'b0;
      if (start_i) begin
        phase_q    <= PH_ADDR;
        cnt_q      <= '0;
        ack_slot_q <= 1'b0;
        sel_q      <= 1'b0;
        oe_q       <= 1'b0;
      end else if (stop_i) begin
        stop_o     <= sel_q;
        phase_q    <= PH_IDLE;
        cnt_q      <= '0;
        ack_slot_q <= 1'b0;
        sel_q      <= 1'b0;
        oe_q       <= 1'b0;
      end else begin
        case (phase_q)
          PH_IDLE, PH_SKIP: ;
          PH_STREAM: begin
            if (scl_rise_i) begin
              step_vld_o <= 1'b1;
              step_up_o  <= sda_i;
            end
          end
          default: begin
            if (scl_rise_i && !ack_slot_q && cnt_q < FULL) begin
              shift_q <= {shift_q[BYTE_W-2:0], sda_i};
              cnt_q   <= cnt_q + 1'b1;
            end
            if (scl_fall_i) begin
              if (ack_slot_q) begin
                // end of ninth clock: release and move on
                ack_slot_q <= 1'b0;
                cnt_q      <= '0;
                oe_q       <= 1'b0;
                case (phase_q)
                  PH_ADDR: phase_q <= PH_INST;
                  PH_INST: begin
                    if (stream_mode_i) phase_q <= PH_STREAM;
                    else if (rd_mode_i) begin
                      phase_q <= PH_READ;
                      tx_q    <= rd_data_i;
                      oe_q    <= ~rd_data_i[BYTE_W-1];
                    end else phase_q <= PH_DATA;
                  end
                  default: phase_q <= PH_SKIP;
                endcase
              end else if (cnt_q == FULL) begin
                ack_slot_q <= 1'b1;
                case (phase_q)
                  PH_ADDR: begin
                    if (addr_hit) begin
                      oe_q  <= 1'b1;
                      sel_q <= 1'b1;
                    end else begin
                      phase_q    <= PH_SKIP;
                      ack_slot_q <= 1'b0;
                    end
                  end
                  PH_INST: begin
                    oe_q       <= 1'b1;
                    inst_vld_o <= 1'b1;
                    byte_o     <= shift_q;
                  end
                  PH_DATA: begin
                    oe_q       <= 1'b1;
                    data_vld_o <= 1'b1;
                    byte_o     <= shift_q;
                  end
                  default: oe_q <= 1'b0;
                endcase
              end else if (phase_q == PH_READ) begin
                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                oe_q <= ~tx_q[BYTE_W-2];
              end
            end
          end
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/twi_cmd_front.sv
module twi_cmd_front #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4,
  parameter int BYTE_W      = 8,
  parameter logic [BYTE_W-ADDR_W-1:0] DEV_TYPE = 4'b0101
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic              nv_busy_i,
  input  logic              rd_mode_i,
  input  logic              stream_mode_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              inst_vld_o,
  output logic              data_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              step_vld_o,
  output logic              step_up_o,
  output logic              stop_o
);
  logic [1:0] bus_s;
  logic       start_ev, stop_ev, rise_ev, fall_ev;

  twi_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (bus_s)
  );

  twi_bus_events u_ev (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (bus_s[1]),
    .sda_s_i   (bus_s[0]),
    .start_o   (start_ev),
    .stop_o    (stop_ev),
    .scl_rise_o(rise_ev),
    .scl_fall_o(fall_ev)
  );

  twi_slave_fsm #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .DEV_TYPE(DEV_TYPE)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_ev),
    .stop_i       (stop_ev),
    .scl_rise_i   (rise_ev),
    .scl_fall_i   (fall_ev),
    .sda_i        (bus_s[0]),
    .dev_addr_i   (dev_addr_i),
    .nv_busy_i    (nv_busy_i),
    .rd_mode_i    (rd_mode_i),
    .stream_mode_i(stream_mode_i),
    .rd_data_i    (rd_data_i),
    .sda_oe_o     (sda_oe_o),
    .inst_vld_o   (inst_vld_o),
    .data_vld_o   (data_vld_o),
    .byte_o       (byte_o),
    .step_vld_o   (step_vld_o),
    .step_up_o    (step_up_o),
    .stop_o       (stop_o)
  );
endmodule

// File: rtl/twi_cmd_front_chk.sv
module twi_cmd_front_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_oe_o,
  input logic inst_vld_o,
  input logic data_vld_o,
  input logic step_vld_o,
  input logic stop_o
);
  // R1
  reset_release_chk: assert property (@(posedge clk_i) !rst_ni |-> !sda_oe_o);

  // R4
  pull_in_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);

  // R12
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({inst_vld_o, data_vld_o, step_vld_o}));

  // R6
  inst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inst_vld_o |=> !inst_vld_o);

  // R8
  step_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_vld_o |=> !step_vld_o);

  // R10
  stop_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !stop_o);
endmodule

bind twi_cmd_front twi_cmd_front_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_i     (scl_i),
  .sda_oe_o  (sda_oe_o),
  .inst_vld_o(inst_vld_o),
  .data_vld_o(data_vld_o),
  .step_vld_o(step_vld_o),
  .stop_o    (stop_o)
);

// File: tb/sim_twi_cmd_front.sv
`timescale 1ns/1ps
module sim_twi_cmd_front;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [3:0] pins = 4'h0;
  logic       busy = 1'b0;
  logic       rd_mode = 1'b0;
  logic       st_mode = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic       sda_oe, inst_vld, data_vld, step_vld, step_up, stop_p;
  logic [7:0] byte_o;
  wire        sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  int inst_cnt = 0, data_cnt = 0, up_cnt = 0, dn_cnt = 0, stop_cnt = 0, multi_cnt = 0;
  logic [7:0] last_inst = 8'h00, last_data = 8'h00;
  logic done = 1'b0;

  always #2 clk = ~clk;

  twi_cmd_front u0 (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .dev_addr_i(pins), .nv_busy_i(busy),
    .rd_mode_i(rd_mode), .stream_mode_i(st_mode), .rd_data_i(rd_data),
    .inst_vld_o(inst_vld), .data_vld_o(data_vld), .byte_o(byte_o),
    .step_vld_o(step_vld), .step_up_o(step_up), .stop_o(stop_p)
  );

  always @(posedge clk) begin
    if (inst_vld) begin inst_cnt <= inst_cnt + 1; last_inst <= byte_o; end
    if (data_vld) begin data_cnt <= data_cnt + 1; last_data <= byte_o; end
    if (step_vld) begin
      if (step_up) up_cnt <= up_cnt + 1; else dn_cnt <= dn_cnt + 1;
    end
    if (stop_p) stop_cnt <= stop_cnt + 1;
    if (int'(inst_vld) + int'(data_vld) + int'(step_vld) > 1) multi_cnt <= multi_cnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic r);
    sda_m = b; wq(Q);
    scl_m = 1'b1; wq(Q);
    r = sda_line; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_start();
    if (!scl_m) begin sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); end
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q * 2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_x(b[i], r);
    bit_x(1'b1, r);
    ack = !r;
  endtask

  function automatic logic exp_ack(input logic [7:0] a, input logic [3:0] p, input logic bz);
    return (a[7:4] == 4'b0101) && (a[3:0] == p) && !bz;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack, a2, a3, r;
    logic [7:0] ad, ins, dat, got;
    int i0, d0, s0, u0c, dn0;
    int unsigned seed;
    seed = 32'h1d5a_0c33;
    void'($urandom(seed));

    wq(5);
    // R1: reset state
    chk("R1 oe in reset", int'(sda_oe), 0);
    rst_ni = 1'b1; wq(10);
    chk("R1 oe after reset", int'(sda_oe), 0);
    chk("R1 no strobes", inst_cnt + data_cnt + up_cnt + dn_cnt + stop_cnt, 0);

    // R2: traffic before any start is ignored
    pins = 4'h6;
    scl_m = 1'b0; wq(Q);
    send_byte(8'h56, ack);
    send_byte(8'h90, a2);
    chk("R2 no ack before start", int'(ack | a2), 0);
    chk("R2 no strobe before start", inst_cnt, 0);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);

    // R3 R4 R6 R11 R10: directed write frame
    bus_start();
    send_byte(8'h56, ack);
    chk("R3 R4 address ack", int'(ack), 1);
    send_byte(8'hC9, a2);
    chk("R4 instruction ack", int'(a2), 1);
    chk("R6 instruction strobe", inst_cnt, 1);
    chk("R6 instruction value", int'(last_inst), 8'hC9);
    send_byte(8'h2B, a3);
    chk("R4 data ack", int'(a3), 1);
    chk("R6 data value", int'(last_data), 8'h2B);
    send_byte(8'h11, ack);
    chk("R11 extra byte no ack", int'(ack), 0);
    chk("R11 extra byte no strobe", data_cnt, 1);
    bus_stop();
    chk("R10 stop pulse", stop_cnt, 1);

    // R3: wrong type nibble, then stop gives no stop pulse
    bus_start();
    send_byte(8'hD6, ack);
    chk("R3 wrong type no ack", int'(ack), 0);
    send_byte(8'hA0, a2);
    chk("R3 no inst after miss", inst_cnt, 1);
    bus_stop();
    chk("R10 no stop pulse unaddressed", stop_cnt, 1);

    // R5: busy refuses, then poll succeeds
    busy = 1'b1;
    bus_start(); send_byte(8'h56, ack); bus_stop();
    chk("R5 busy no ack", int'(ack), 0);
    busy = 1'b0;
    bus_start(); send_byte(8'h56, ack);
    chk("R5 ack after busy clears", int'(ack), 1);
    bus_stop();

    // R7: read byte
    rd_data = 8'($urandom());
    rd_mode = 1'b1;
    bus_start(); send_byte(8'h56, ack);
    send_byte(8'hB2, a2);
    got = '0;
    for (int i = 7; i >= 0; i--) begin bit_x(1'b1, r); got[i] = r; end
    chk("R7 read data", int'(got), int'(rd_data));
    bit_x(1'b0, r);
    sda_m = 1'b1;
    chk("R7 released in ninth", int'(sda_oe), 0);
    bus_stop();
    rd_mode = 1'b0;

    // R8: stream steps
    st_mode = 1'b1;
    bus_start(); send_byte(8'h56, ack); send_byte(8'h20, a2);
    u0c = up_cnt; dn0 = dn_cnt;
    begin
      int ups = 0;
      for (int i = 0; i < 13; i++) begin
        logic b = 1'($urandom());
        if (b) ups++;
        bit_x(b, r);
      end
      chk("R8 up steps", up_cnt - u0c, ups);
      chk("R8 down steps", dn_cnt - dn0, 13 - ups);
    end
    bus_stop();
    st_mode = 1'b0;
    u0c = up_cnt;
    bus_start(); send_byte(8'h56, ack); bus_stop();
    chk("R8 stream ends at stop", up_cnt - u0c, 0);

    // R9: restart mid-byte
    bus_start();
    for (int i = 0; i < 4; i++) bit_x(1'b1, r);
    i0 = inst_cnt;
    bus_start();
    send_byte(8'h56, ack);
    send_byte(8'h9E, a2);
    chk("R9 ack after restart", int'(ack & a2), 1);
    chk("R9 inst after restart", int'(last_inst), 8'h9E);
    chk("R9 inst count", inst_cnt - i0, 1);
    bus_stop();

    // R3 R6: random frames
    for (int n = 0; n < 20; n++) begin
      logic e;
      pins = 4'($urandom());
      busy = ($urandom() % 6) == 0;
      case ($urandom() % 3)
        0: ad = {4'b0101, pins};
        1: ad = {4'b0101, pins ^ 4'(1 << ($urandom() % 4))};
        default: ad = {4'($urandom()), 4'($urandom())};
      endcase
      ins = 8'($urandom()); dat = 8'($urandom());
      e = exp_ack(ad, pins, busy);
      i0 = inst_cnt; d0 = data_cnt; s0 = stop_cnt;
      bus_start();
      send_byte(ad, ack);
      send_byte(ins, a2);
      send_byte(dat, a3);
      bus_stop();
      chk("R3 R5 random address ack", int'(ack), int'(e));
      chk("R6 random inst count", inst_cnt - i0, int'(e));
      chk("R6 random data count", data_cnt - d0, int'(e));
      if (e) begin
        chk("R6 random inst value", int'(last_inst), int'(ins));
        chk("R6 random data value", int'(last_data), int'(dat));
      end
      chk("R10 random stop", stop_cnt - s0, int'(e));
    end
    busy = 1'b0;

    chk("R12 strobes exclusive", multi_cnt, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule